// File: doc/BRIEF.md
# Burst Write Page Cache Controller

This block collects a burst of write bytes into a small staging cache and, once the burst is closed, writes the cache out to a larger page-organised memory array. The array is written one page per write operation. The cache holds `PAGE_BYTES * CACHE_PAGES` bytes, which is 8 pages of 8 bytes by default. A burst opens with a one-cycle start pulse that carries a byte address. Each data strobe then deposits one byte. A one-cycle stop pulse closes the burst.

Loading always begins in cache page 0, at the byte offset given by the low address bits. If loading runs past the end of the cache, it wraps back into page 0 and overwrites what is there. When the stop pulse arrives, every cache page that holds at least one loaded byte is written, in ascending cache page order. Each write goes to the array page at the start page plus the cache page number, modulo the array size. Each page write is a single-cycle strobe. A programmable settle time of `CYCLE_TICKS` clocks follows each strobe and models the array's programming time. While this happens, `busy` is high and all burst inputs are ignored.

`PAGE_BYTES`, `CACHE_PAGES` and `ARRAY_PAGES` are powers of two, and `ARRAY_PAGES >= CACHE_PAGES`.

Top module: `page_cache_writer`

## Requirements
- R1: After reset, `busy` and `arrWrEn` are both 0.
- R2: After a start pulse with address A, the first data byte is placed in cache page 0 at offset A[2:0], and each later byte goes to the next cache position. In a page write, mask bit i and data bits [8i+7:8i] belong to byte offset i of that page.
- R3: A byte loaded after the last cache position goes to cache byte 0 (page 0, offset 0), and loading continues from there. Any byte already stored at a position is replaced by the newer one.
- R4: Cache page k is written to array page (A[6:3] + k) mod `ARRAY_PAGES`, where A is the start address. The result may wrap past the last array page.
- R5: A page write masks in exactly the byte positions loaded in the current burst. A cache page with no loaded bytes gets no write strobe and uses no settle time.
- R6: The first write strobe comes in the cycle after the stop pulse is sampled. Touched pages are written in ascending cache page order. Consecutive strobes are exactly `CYCLE_TICKS`+1 cycles apart, whether a page is full or partial.
- R7: `busy` rises together with the first write strobe. It stays high until `CYCLE_TICKS` cycles after the last strobe, then falls.
- R8: Start, data and stop pulses applied while `busy` is high have no effect. Neither the current write-out nor any later burst is changed by them.
- R9: A stop pulse with no bytes loaded returns the block to idle. It produces no write strobe and `busy` is never asserted.
- R10: When a write-out finishes, all loaded-byte marks are cleared, so the next burst writes only its own bytes.
- R11: Data strobes and stop pulses applied while idle, before any start pulse, are ignored.
- R12: A start pulse during loading begins a fresh burst. Bytes loaded so far are discarded, and the new address sets the new start page and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Opens a burst at `startAddr` |
| startAddr | input | 7 | Byte address of the first byte: array page in [6:3], offset in [2:0] |
| dataStrobe | input | 1 | Loads `dataByte` into the cache |
| dataByte | input | 8 | Write data byte |
| stopPulse | input | 1 | Closes the burst and starts the write-out |
| arrWrEn | output | 1 | One-cycle array page write strobe |
| arrPage | output | 4 | Target array page index |
| arrData | output | 64 | Page data; byte i is in bits [8i+7:8i] |
| arrMask | output | 8 | Per-byte write enables for the page |
| busy | output | 1 | Write-out in progress |

## Verification
The hardest state to reach is a cache page 0 that holds bytes from two ends of the burst. This happens when a burst starts at a non-zero offset, loads more than the full cache, and wraps. The page is then written with a mix of the newest and oldest data, while the last page keeps its earlier contents. The bench reaches it with a full 64-byte burst starting at offset 2 near the top of the array, so the page index wraps too. A second burst starts at offset 0 and loads 66 bytes, which forces overwrites. The "ignored while busy" case is reached by driving start, data and stop pulses inside a two-page settle window. A bare stop afterwards then shows that no burst was secretly opened.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WAIT  = 2'd3
  } pcState_t;

  typedef struct packed {
    logic captureStart;
    logic storeByte;
    logic clearAll;
  } pcStrobe_t;

endpackage

// File: rtl/pcache_datapath.sv
module pcache_datapath
  import pcache_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  parameter int ARRAY_PAGES = 16,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int CP_W        = $clog2(CACHE_PAGES),
  localparam int AP_W        = $clog2(ARRAY_PAGES),
  localparam int ADDR_W      = AP_W + OFF_W,
  localparam int CACHE_BYTES = PAGE_BYTES * CACHE_PAGES,
  localparam int PTR_W       = $clog2(CACHE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pcStrobe_t               strb,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [7:0]              dataByte,
  input  logic [CP_W-1:0]         selPage,
  output logic [CACHE_PAGES-1:0]  touched,
  output logic [PAGE_BYTES*8-1:0] pageData,
  output logic [PAGE_BYTES-1:0]   pageMask,
  output logic [AP_W-1:0]         arrPage
);

  logic [7:0]             cacheMem [CACHE_BYTES];
  logic [CACHE_BYTES-1:0] validBits;
  logic [PTR_W-1:0]       loadPtr;
  logic [AP_W-1:0]        startPage;

  // Pointer, valid marks and start page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
      loadPtr   <= '0;
      startPage <= '0;
    end else if (strb.captureStart) begin
      validBits <= '0;
      loadPtr   <= PTR_W'(startAddr[OFF_W-1:0]);
      startPage <= startAddr[ADDR_W-1:OFF_W];
    end else if (strb.storeByte) begin
      validBits[loadPtr] <= 1'b1;
      loadPtr            <= loadPtr + 1'b1;  // natural wrap to cache byte 0
    end else if (strb.clearAll) begin
      validBits <= '0;
    end
  end

  // Data storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.storeByte && !strb.captureStart) cacheMem[loadPtr] <= dataByte;
  end

  for (genvar p = 0; p < CACHE_PAGES; p++) begin : g_touch
    assign touched[p] = |validBits[p*PAGE_BYTES +: PAGE_BYTES];
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_rd
    assign pageData[b*8 +: 8] = cacheMem[{selPage, OFF_W'(b)}];
  end

  assign pageMask = validBits[selPage*PAGE_BYTES +: PAGE_BYTES];
  assign arrPage  = startPage + AP_W'(selPage);

  p_store_sets_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeByte && !strb.captureStart) |=> validBits[$past(loadPtr)]);

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeByte && !strb.captureStart && (&loadPtr)) |=> (loadPtr == '0));

endmodule

// File: rtl/pcache_control.sv
module pcache_control
  import pcache_pkg::*;
#(
  parameter int CACHE_PAGES = 8,
  parameter int CYCLE_TICKS = 6,
  localparam int CP_W = $clog2(CACHE_PAGES),
  localparam int TM_W = $clog2(CYCLE_TICKS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startPulse,
  input  logic                   dataStrobe,
  input  logic                   stopPulse,
  input  logic [CACHE_PAGES-1:0] touched,
  output pcStrobe_t              strb,
  output logic [CP_W-1:0]        selPage,
  output logic                   arrWrEn,
  output logic                   busy
);

  pcState_t        state, stateNx;
  logic [CP_W-1:0] curPage;
  logic [TM_W-1:0] timer;
  logic            nextFound;
  logic [CP_W-1:0] nextIdx;
  int              searchBase;

  // Lowest touched page at or above the search base
  always_comb begin
    searchBase = (state == ST_LOAD) ? 0 : int'(curPage) + 1;
    nextFound  = 1'b0;
    nextIdx    = '0;
    for (int p = 0; p < CACHE_PAGES; p++) begin
      if (!nextFound && p >= searchBase && touched[p]) begin
        nextFound = 1'b1;
        nextIdx   = CP_W'(p);
      end
    end
  end

  always_comb begin
    stateNx = state;
    strb    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.captureStart = 1'b1;
          stateNx = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (startPulse) begin
          strb.captureStart = 1'b1;
        end else if (stopPulse) begin
          stateNx = nextFound ? ST_WRITE : ST_IDLE;
        end else if (dataStrobe) begin
          strb.storeByte = 1'b1;
        end
      end
      ST_WRITE: stateNx = ST_WAIT;
      ST_WAIT: begin
        if (timer == '0) begin
          if (nextFound) stateNx = ST_WRITE;
          else begin
            stateNx       = ST_IDLE;
            strb.clearAll = 1'b1;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curPage <= '0;
      timer   <= '0;
    end else begin
      state <= stateNx;
      if (stateNx == ST_WRITE) curPage <= nextIdx;
      if (state == ST_WRITE) timer <= TM_W'(CYCLE_TICKS - 1);
      else if (state == ST_WAIT && timer != '0) timer <= timer - 1'b1;
    end
  end

  assign selPage = curPage;
  assign arrWrEn = (state == ST_WRITE);
  assign busy    = (state == ST_WRITE) || (state == ST_WAIT);

  p_write_touched_r5: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> touched[curPage]);

  p_strobe_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |=> !arrWrEn);

  p_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  p_marks_cleared_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy)) |-> (touched == '0));

endmodule

// File: rtl/page_cache_writer.sv
module page_cache_writer
  import pcache_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  parameter int ARRAY_PAGES = 16,
  parameter int CYCLE_TICKS = 6,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int CP_W   = $clog2(CACHE_PAGES),
  localparam int AP_W   = $clog2(ARRAY_PAGES),
  localparam int ADDR_W = AP_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic                    dataStrobe,
  input  logic [7:0]              dataByte,
  input  logic                    stopPulse,
  output logic                    arrWrEn,
  output logic [AP_W-1:0]         arrPage,
  output logic [PAGE_BYTES*8-1:0] arrData,
  output logic [PAGE_BYTES-1:0]   arrMask,
  output logic                    busy
);

  pcStrobe_t              strb;
  logic [CP_W-1:0]        selPage;
  logic [CACHE_PAGES-1:0] touched;

  pcache_control #(
    .CACHE_PAGES(CACHE_PAGES),
    .CYCLE_TICKS(CYCLE_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .dataStrobe(dataStrobe),
    .stopPulse (stopPulse),
    .touched   (touched),
    .strb      (strb),
    .selPage   (selPage),
    .arrWrEn   (arrWrEn),
    .busy      (busy)
  );

  pcache_datapath #(
    .PAGE_BYTES (PAGE_BYTES),
    .CACHE_PAGES(CACHE_PAGES),
    .ARRAY_PAGES(ARRAY_PAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startAddr(startAddr),
    .dataByte (dataByte),
    .selPage  (selPage),
    .touched  (touched),
    .pageData (arrData),
    .pageMask (arrMask),
    .arrPage  (arrPage)
  );

endmodule

// File: tb/tb_page_cache_writer.sv
module tb_page_cache_writer;

  localparam int CLK_PERIOD = 10;
  localparam int PB = 8;
  localparam int CP = 8;
  localparam int AP = 16;
  localparam int CT = 6;
  localparam int CB = PB * CP;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [6:0]  startAddr = '0;
  logic        dataStrobe = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        stopPulse = 1'b0;
  logic        arrWrEn;
  logic [3:0]  arrPage;
  logic [63:0] arrData;
  logic [7:0]  arrMask;
  logic        busy;

  page_cache_writer #(.PAGE_BYTES(PB), .CACHE_PAGES(CP), .ARRAY_PAGES(AP), .CYCLE_TICKS(CT)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .dataStrobe(dataStrobe), .dataByte(dataByte), .stopPulse(stopPulse),
    .arrWrEn(arrWrEn), .arrPage(arrPage), .arrData(arrData), .arrMask(arrMask), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Record of write strobes
  int         recN = 0;
  int         recCyc  [64];
  logic [3:0] recPage [64];
  logic [63:0] recData [64];
  logic [7:0] recMask [64];

  always @(negedge clk) begin
    if (rstN && arrWrEn && recN < 64) begin
      recCyc[recN]  = cyc;
      recPage[recN] = arrPage;
      recData[recN] = arrData;
      recMask[recN] = arrMask;
      recN++;
    end
  end

  // Reference model built from the requirements
  logic [7:0] mCache [CB];
  bit         mValid [CB];
  int         mPtr = 0;
  int         mSp = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doStart(input int addr, input bit track);
    startAddr  = 7'(addr);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (track) begin
      mSp  = addr / PB;
      mPtr = addr % PB;
      for (int i = 0; i < CB; i++) mValid[i] = 0;
    end
  endtask

  task automatic doByte(input logic [7:0] b, input bit track);
    dataByte   = b;
    dataStrobe = 1'b1;
    @(negedge clk);
    dataStrobe = 1'b0;
    if (track) begin
      mCache[mPtr] = b;
      mValid[mPtr] = 1;
      mPtr = (mPtr + 1) % CB;
    end
  endtask

  task automatic doStop();
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic clearModel();
    for (int i = 0; i < CB; i++) mValid[i] = 0;
  endtask

  // Compare recorded strobes to the model's expected write-out
  task automatic checkCommit(input string tag);
    int expN = 0;
    int k;
    int n;
    logic [7:0] eMask;
    for (k = 0; k < CP; k++) begin
      eMask = '0;
      for (int b = 0; b < PB; b++) if (mValid[k*PB+b]) eMask[b] = 1'b1;
      if (eMask != 0) begin
        if (expN < recN) begin
          chk(recPage[expN] == 4'((mSp + k) % AP), "R4", {tag, " page"}, recPage[expN], (mSp + k) % AP);
          chk(recMask[expN] == eMask, "R5", {tag, " mask"}, recMask[expN], eMask);
          for (int b = 0; b < PB; b++)
            if (eMask[b])
              chk(recData[expN][b*8 +: 8] == mCache[k*PB+b], "R2/R3", {tag, " data"},
                  recData[expN][b*8 +: 8], mCache[k*PB+b]);
          if (expN > 0)
            chk(recCyc[expN] - recCyc[expN-1] == CT + 1, "R6", {tag, " strobe spacing"},
                recCyc[expN] - recCyc[expN-1], CT + 1);
        end
        expN++;
      end
    end
    n = recN;
    chk(n == expN, "R5/R6", {tag, " write count"}, n, expN);
    clearModel();
    recN = 0;
  endtask

  // R1
  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(arrWrEn == 1'b0, "R1", "arrWrEn after reset", arrWrEn, 0);
  endtask

  // R2, R4, R6, R7: aligned burst spanning two pages
  task automatic t_aligned();
    int stopCyc;
    int n;
    recN = 0;
    doStart(24, 1);
    for (int i = 0; i < 10; i++) doByte(8'(8'h10 + i), 1);
    doStop();
    stopCyc = cyc;
    chk(busy == 1'b1, "R7", "busy rises with first strobe", busy, 1);
    chk(arrWrEn == 1'b1, "R6", "strobe in cycle after stop", arrWrEn, 1);
    waitIdle();
    // last strobe at stopCyc + CT+1; busy falls CT cycles after it
    chk(cyc - stopCyc == 2*(CT+1), "R7", "busy duration", cyc - stopCyc, 2*(CT+1));
    n = recN;
    chk(n == 2, "R6", "aligned page count", n, 2);
    checkCommit("aligned");
  endtask

  // R3, R4: full cache from offset 2 near the array top
  task automatic t_wrap_full();
    recN = 0;
    doStart(14*PB + 2, 1);
    for (int i = 0; i < CB; i++) doByte(8'(i + 8'h40), 1);
    doStop();
    waitIdle();
    checkCommit("full wrap");
  endtask

  // R3: overflow overwrites page 0
  task automatic t_overflow();
    recN = 0;
    doStart(0, 1);
    for (int i = 0; i < CB + 2; i++) doByte(8'(8'hA0 ^ i), 1);
    doStop();
    waitIdle();
    checkCommit("overflow");
  endtask

  // R5: partial page, bytes at offsets 5 and 6 only
  task automatic t_partial();
    recN = 0;
    doStart(5, 1);
    doByte(8'h5A, 1);
    doByte(8'hC3, 1);
    doStop();
    waitIdle();
    chk(recN == 1 && recMask[0] == 8'h60, "R5", "partial mask", recMask[0], 8'h60);
    checkCommit("partial");
  endtask

  // R8: pulses during busy are ignored
  task automatic t_busy_ignore();
    recN = 0;
    doStart(40, 1);
    for (int i = 0; i < 12; i++) doByte(8'(8'h70 + i), 1);
    doStop();
    doStart(0, 0);
    doByte(8'hEE, 0);
    doByte(8'hEF, 0);
    doStop();
    chk(busy == 1'b1, "R8", "still busy during ignored pulses", busy, 1);
    waitIdle();
    checkCommit("busy ignore");
    doStop();
    chk(busy == 1'b0, "R8", "no burst opened by ignored start", busy, 0);
    repeat (CT + 3) @(negedge clk);
    chk(recN == 0, "R8", "no writes after ignored pulses", recN, 0);
  endtask

  // R9: stop with nothing loaded
  task automatic t_empty_stop();
    int b1 = 0;
    recN = 0;
    doStart(16, 1);
    doStop();
    for (int i = 0; i < CT + 3; i++) begin
      if (busy) b1 = 1;
      @(negedge clk);
    end
    chk(b1 == 0, "R9", "busy never asserted", b1, 0);
    chk(recN == 0, "R9", "no writes for empty burst", recN, 0);
  endtask

  // R10, R11: idle strobes ignored, stale marks cleared
  task automatic t_idle_and_clear();
    recN = 0;
    doByte(8'h11, 0);
    doByte(8'h22, 0);
    doStop();
    chk(busy == 1'b0 && recN == 0, "R11", "idle strobes inert", recN, 0);
    doStart(8, 1);
    doByte(8'h99, 1);
    doStop();
    waitIdle();
    chk(recN == 1 && recMask[0] == 8'h01, "R10", "only new byte written", recMask[0], 8'h01);
    checkCommit("after clear");
  endtask

  // R12: restart discards earlier bytes
  task automatic t_restart();
    recN = 0;
    doStart(0, 1);
    for (int i = 0; i < 3; i++) doByte(8'(8'h30 + i), 1);
    doStart(16, 1);
    doByte(8'h77, 1);
    doStop();
    waitIdle();
    chk(recN == 1 && recPage[0] == 4'd2 && recMask[0] == 8'h01, "R12", "restart page/mask",
        {recPage[0], recMask[0]}, {4'd2, 8'h01});
    checkCommit("restart");
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_wrap_full();
    t_overflow();
    t_partial();
    t_busy_ignore();
    t_empty_stop();
    t_idle_and_clear();
    t_restart();
    finish();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish();
  end

endmodule